// File: doc/BRIEF.md
# DMA chunked copy engine

This block is the sequencer and datapath of a single DMA channel. A control register block presents a pending descriptor made of a configuration word, a byte count, a destination address and a source address. A one-cycle start pulse copies that descriptor into the engine's working registers. The engine then moves the data through a simple request/acknowledge memory port. Each step reads one chunk from the source and writes it to the destination. After each write, both working addresses go up and the remaining count goes down.

The chunk size comes from a three-bit size field of the configuration word. It is two to the power of that field, limited to the data port width of eight bytes. The engine moves whole chunks first and then one shorter transfer for any bytes that are left. It flags an error before any memory access if the count is zero or either address is not aligned to the chunk size. A response error on the memory port stops the copy at once and is also reported as an error. When the repeat bit is set, the working count and both addresses are put back to their start values after a successful copy. The control block then sees them ready for another pass.

Configuration word: bits [2:0] hold the size field and bit 3 is the repeat flag.

States and transitions:
- `ST_IDLE` goes to `ST_CHECK` on start.
- `ST_CHECK` goes to `ST_FAULT` if the descriptor is bad, and to `ST_READ` otherwise.
- `ST_READ` goes to `ST_WRITE` on a clean acknowledge, and to `ST_FAULT` on an error response.
- `ST_WRITE` goes to `ST_READ` while bytes remain, to `ST_DONE` after the last transfer, and to `ST_FAULT` on an error response.
- `ST_DONE` and `ST_FAULT` go to `ST_IDLE` after one cycle.

Top module: `dma_chunk_engine`

## Requirements
- R1: After reset the engine is idle. It issues no memory request, does not pulse done or error, and its working registers read zero.
- R2: A start pulse seen while idle latches config, count, destination and source into the working registers. In the following cycle `clr_flags_o` pulses for one cycle and `busy_o` is high.
- R3: The chunk length is 2^size with the size field in config bits [2:0]. Any field value above 3 gives 8 bytes.
- R4: Each chunk is one read request at the working source followed by one write request at the working destination. Both carry the same length in `mem_size_o`, and the write carries the bytes returned by the read in its low lanes. A request holds until acknowledged.
- R5: A clean write acknowledge adds the transfer length to both working addresses and subtracts it from the working count.
- R6: Whole chunks move first. A remainder shorter than one chunk moves last in a single transfer of exactly that length, so the destination ends up equal to the source.
- R7: A zero count, or a source or destination not aligned to the chunk length, raises `err_o` without any memory request and leaves the working registers as latched.
- R8: An error response to a read or a write stops the copy. No further request is issued, and `err_o` pulses once with no done pulse.
- R9: After the last clean write acknowledge, `done_o` pulses for exactly one cycle, in the cycle that follows the acknowledge.
- R10: With the repeat bit (config bit 3) set, the working count, destination and source hold their start values once the done pulse has passed.
- R11: A start pulse while the engine is busy is ignored and does not disturb the copy in progress.
- R12: After a done or error pulse the engine returns to idle and accepts the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start pulse |
| nxt_cfg_i | input | 4 | Pending config: [2:0] size field, [3] repeat |
| nxt_bytes_i | input | CNT_W | Pending byte count |
| nxt_dst_i | input | ADDR_W | Pending destination address |
| nxt_src_i | input | ADDR_W | Pending source address |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_size_o | output | LEN_W | Transfer length in bytes |
| mem_wdata_o | output | DATA_W | Write data, byte k of the transfer in lane k |
| mem_rdata_i | input | DATA_W | Read data, byte k in lane k |
| mem_ack_i | input | 1 | Request accepted and completed |
| mem_err_i | input | 1 | Error response, valid with ack |
| exec_cfg_o | output | 4 | Working config |
| exec_bytes_o | output | CNT_W | Working remaining count |
| exec_dst_o | output | ADDR_W | Working destination |
| exec_src_o | output | ADDR_W | Working source |
| busy_o | output | 1 | Engine not idle |
| clr_flags_o | output | 1 | Pulse: clear done and error flags |
| done_o | output | 1 | Pulse: copy completed |
| err_o | output | 1 | Pulse: copy failed |

## Verification
A wrong working register or a wrong state shows at the memory port within one request. The next address or length no longer matches the request sequence the bench predicts for the descriptor, and the bench compares every handshake as it happens. A sequencer that skips or repeats a step shows as an unexpected or missing request, or as a done or error pulse that is missing, doubled or badly placed. The pulse is seen in the cycle after the last acknowledge. Latching and repeat faults show in the working registers right after start and right after completion. Data-path faults show in the destination bytes.

// File: rtl/dma_chunk_pkg.sv
package dma_chunk_pkg;
    localparam int CFG_W    = 4;
    localparam int SZ_FLD_W = 3;
    localparam int RPT_BIT  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_WRITE,
        ST_DONE,
        ST_FAULT
    } eng_state_t;
endpackage

// File: rtl/dma_chunk_sizer.sv
module dma_chunk_sizer
    import dma_chunk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int LEN_W  = 4
) (
    input  logic [SZ_FLD_W-1:0] size_fld,
    input  logic [CNT_W-1:0]    bytes_left,
    input  logic [ADDR_W-1:0]   src_addr,
    input  logic [ADDR_W-1:0]   dst_addr,
    output logic [LEN_W-1:0]    xfer_len,
    output logic                last_chunk,
    output logic                desc_bad
);
    localparam int MAX_LOG2 = LEN_W - 1;

    logic [SZ_FLD_W-1:0] lg;
    logic [LEN_W-1:0]    chunk;
    logic [ADDR_W-1:0]   amask;

    always_comb begin
        lg         = (int'(size_fld) > MAX_LOG2) ? SZ_FLD_W'(MAX_LOG2) : size_fld;
        chunk      = LEN_W'(1) << lg;
        amask      = ADDR_W'(chunk) - ADDR_W'(1);
        last_chunk = (bytes_left <= CNT_W'(chunk));
        xfer_len   = last_chunk ? bytes_left[LEN_W-1:0] : chunk;
        desc_bad   = (bytes_left == '0) || (|(src_addr & amask)) || (|(dst_addr & amask));
    end
endmodule

// File: rtl/dma_chunk_fsm.sv
module dma_chunk_fsm
    import dma_chunk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       desc_bad,
    input  logic       last_chunk,
    input  logic       mem_ack,
    input  logic       mem_err,
    output eng_state_t state
);
    eng_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_CHECK;
            ST_CHECK: nxt = desc_bad ? ST_FAULT : ST_READ;
            ST_READ:  if (mem_ack) nxt = mem_err ? ST_FAULT : ST_WRITE;
            ST_WRITE: if (mem_ack) begin
                          if (mem_err)         nxt = ST_FAULT;
                          else if (last_chunk) nxt = ST_DONE;
                          else                 nxt = ST_READ;
                      end
            ST_DONE:  nxt = ST_IDLE;
            ST_FAULT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/dma_chunk_regs.sv
module dma_chunk_regs
    import dma_chunk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 64,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  eng_state_t        state,
    input  logic              load,
    input  logic [CFG_W-1:0]  nxt_cfg,
    input  logic [CNT_W-1:0]  nxt_bytes,
    input  logic [ADDR_W-1:0] nxt_dst,
    input  logic [ADDR_W-1:0] nxt_src,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CFG_W-1:0]  exec_cfg,
    output logic [CNT_W-1:0]  exec_bytes,
    output logic [ADDR_W-1:0] exec_dst,
    output logic [ADDR_W-1:0] exec_src,
    output logic [DATA_W-1:0] data_buf
);
    logic [CNT_W-1:0]  sv_bytes;
    logic [ADDR_W-1:0] sv_dst;
    logic [ADDR_W-1:0] sv_src;
    logic              beat_ok;

    assign beat_ok = mem_ack && !mem_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_cfg   <= '0;
            exec_bytes <= '0;
            exec_dst   <= '0;
            exec_src   <= '0;
            sv_bytes   <= '0;
            sv_dst     <= '0;
            sv_src     <= '0;
            data_buf   <= '0;
        end else if (load) begin
            exec_cfg   <= nxt_cfg;
            exec_bytes <= nxt_bytes;
            exec_dst   <= nxt_dst;
            exec_src   <= nxt_src;
            sv_bytes   <= nxt_bytes;
            sv_dst     <= nxt_dst;
            sv_src     <= nxt_src;
        end else begin
            if (state == ST_READ && beat_ok) begin
                data_buf <= mem_rdata;
            end
            if (state == ST_WRITE && beat_ok) begin
                exec_src   <= exec_src + ADDR_W'(xfer_len);
                exec_dst   <= exec_dst + ADDR_W'(xfer_len);
                exec_bytes <= exec_bytes - CNT_W'(xfer_len);
            end
            if (state == ST_DONE && exec_cfg[RPT_BIT]) begin
                exec_bytes <= sv_bytes;
                exec_dst   <= sv_dst;
                exec_src   <= sv_src;
            end
        end
    end
endmodule

// File: rtl/dma_chunk_engine.sv
module dma_chunk_engine
    import dma_chunk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 64,
    localparam int NLANES = DATA_W / 8,
    localparam int LEN_W  = $clog2(NLANES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CFG_W-1:0]  nxt_cfg_i,
    input  logic [CNT_W-1:0]  nxt_bytes_i,
    input  logic [ADDR_W-1:0] nxt_dst_i,
    input  logic [ADDR_W-1:0] nxt_src_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [LEN_W-1:0]  mem_size_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    input  logic              mem_err_i,
    output logic [CFG_W-1:0]  exec_cfg_o,
    output logic [CNT_W-1:0]  exec_bytes_o,
    output logic [ADDR_W-1:0] exec_dst_o,
    output logic [ADDR_W-1:0] exec_src_o,
    output logic              busy_o,
    output logic              clr_flags_o,
    output logic              done_o,
    output logic              err_o
);
    eng_state_t        state;
    logic              load;
    logic              desc_bad;
    logic              last_chunk;
    logic [LEN_W-1:0]  xfer_len;
    logic [DATA_W-1:0] data_buf;

    assign load = (state == ST_IDLE) && start_i;

    dma_chunk_sizer #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W),
        .LEN_W (LEN_W)
    ) u_sizer (
        .size_fld  (exec_cfg_o[SZ_FLD_W-1:0]),
        .bytes_left(exec_bytes_o),
        .src_addr  (exec_src_o),
        .dst_addr  (exec_dst_o),
        .xfer_len  (xfer_len),
        .last_chunk(last_chunk),
        .desc_bad  (desc_bad)
    );

    dma_chunk_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .desc_bad  (desc_bad),
        .last_chunk(last_chunk),
        .mem_ack   (mem_ack_i),
        .mem_err   (mem_err_i),
        .state     (state)
    );

    dma_chunk_regs #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W),
        .DATA_W(DATA_W),
        .LEN_W (LEN_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .load      (load),
        .nxt_cfg   (nxt_cfg_i),
        .nxt_bytes (nxt_bytes_i),
        .nxt_dst   (nxt_dst_i),
        .nxt_src   (nxt_src_i),
        .xfer_len  (xfer_len),
        .mem_ack   (mem_ack_i),
        .mem_err   (mem_err_i),
        .mem_rdata (mem_rdata_i),
        .exec_cfg  (exec_cfg_o),
        .exec_bytes(exec_bytes_o),
        .exec_dst  (exec_dst_o),
        .exec_src  (exec_src_o),
        .data_buf  (data_buf)
    );

    // Output decode from the state register.
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = exec_src_o;
        clr_flags_o = 1'b0;
        done_o      = 1'b0;
        err_o       = 1'b0;
        busy_o      = 1'b1;
        unique case (state)
            ST_IDLE:  busy_o = 1'b0;
            ST_CHECK: clr_flags_o = 1'b1;
            ST_READ:  mem_req_o = 1'b1;
            ST_WRITE: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = exec_dst_o;
            end
            ST_DONE:  done_o = 1'b1;
            ST_FAULT: err_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    assign mem_size_o = xfer_len;

    // Byte lanes beyond the transfer length are driven to zero.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        assign mem_wdata_o[8*g +: 8] = (LEN_W'(g) < xfer_len) ? data_buf[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/dma_chunk_engine_chk.sv
module dma_chunk_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [LEN_W-1:0]  mem_size_o,
    input logic              mem_ack_i,
    input logic              mem_err_i,
    input logic [CNT_W-1:0]  exec_bytes_o,
    input logic [ADDR_W-1:0] exec_src_o,
    input logic              busy_o,
    input logic              clr_flags_o,
    input logic              done_o,
    input logic              err_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o); // R1

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> clr_flags_o); // R2

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_size_o != '0 && mem_size_o <= LEN_W'(1 << (LEN_W - 1)))); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_size_o))); // R4

    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_ack_i && !mem_err_i) |=>
        (exec_src_o == $past(exec_src_o) + ADDR_W'($past(mem_size_o)) &&
         exec_bytes_o == $past(exec_bytes_o) - CNT_W'($past(mem_size_o)))); // R5

    AST_FAULT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!mem_req_o && !busy_o)); // R8

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_req_o && mem_we_o && mem_ack_i && !mem_err_i)); // R9

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
endmodule

bind dma_chunk_engine dma_chunk_engine_chk #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .LEN_W (LEN_W)
) u_chk (.*);

// File: tb/tb_dma_chunk_engine.sv
module tb_dma_chunk_engine;
    localparam int CLK_P = 10;
    localparam int AW = 32;
    localparam int CW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [3:0]    nxt_cfg_i = '0;
    logic [CW-1:0] nxt_bytes_i = '0;
    logic [AW-1:0] nxt_dst_i = '0;
    logic [AW-1:0] nxt_src_i = '0;
    logic          mem_req_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [3:0]    mem_size_o;
    logic [DW-1:0] mem_wdata_o;
    logic [DW-1:0] mem_rdata_i = '0;
    logic          mem_ack_i = 1'b0;
    logic          mem_err_i = 1'b0;
    logic [3:0]    exec_cfg_o;
    logic [CW-1:0] exec_bytes_o;
    logic [AW-1:0] exec_dst_o, exec_src_o;
    logic          busy_o, clr_flags_o, done_o, err_o;

    always #(CLK_P/2) clk = ~clk;

    dma_chunk_engine #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) dut (.*);

    int n_chk = 0, n_fail = 0;
    logic [7:0] mem [0:1023];
    bit exp_we[$];
    int exp_addr[$];
    int exp_len[$];
    int err_at = -1, acc_idx = 0, done_cnt = 0, err_cnt = 0;
    bit last_wr_ok = 1'b0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Reference memory and request-sequence model, compared every clock.
    always @(negedge clk) begin : mem_model
        bit ew, inj;
        int ea, el;
        if (rst_n) begin
            if (done_o) begin
                done_cnt++;
                chk(mem_ack_i && last_wr_ok, "R9 done follows last write ack", mem_ack_i, 1);
            end
            if (err_o) err_cnt++;
            if (!busy_o && mem_req_o) chk(0, "R1 request while idle", mem_req_o, 0);
        end
        if (mem_ack_i) begin
            mem_ack_i = 1'b0;
            mem_err_i = 1'b0;
            last_wr_ok = 1'b0;
        end else if (mem_req_o) begin
            if (exp_we.size() == 0) begin
                chk(0, "R8 unexpected request", mem_addr_o, 0);
            end else begin
                ew = exp_we.pop_front();
                ea = exp_addr.pop_front();
                el = exp_len.pop_front();
                chk(mem_we_o == ew && int'(mem_addr_o) == ea && int'(mem_size_o) == el,
                    "R3 R4 request kind, address, length",
                    {mem_we_o, mem_size_o, mem_addr_o}, {ew, 4'(el), 32'(ea)});
            end
            inj = (acc_idx == err_at);
            acc_idx++;
            mem_err_i = inj;
            if (!mem_we_o) begin
                for (int k = 0; k < 8; k++) mem_rdata_i[8*k +: 8] = mem[(int'(mem_addr_o) + k) & 1023];
            end else if (!inj) begin
                for (int k = 0; k < int'(mem_size_o); k++)
                    mem[(int'(mem_addr_o) + k) & 1023] = mem_wdata_o[8*k +: 8];
            end
            last_wr_ok = mem_we_o && !inj;
            mem_ack_i = 1'b1;
        end
    end

    task automatic run_case(input logic [3:0] cfg, input int nbytes, input int src, input int dst,
                            input int e_at, input bit poke, input string name);
        int lg, csz, total, dc0, ec0, mism, cyc, len;
        bit bad, exp_err;
        lg = (int'(cfg[2:0]) > 3) ? 3 : int'(cfg[2:0]);
        csz = 1 << lg;
        bad = (nbytes == 0) || (src % csz != 0) || (dst % csz != 0);
        exp_we.delete(); exp_addr.delete(); exp_len.delete();
        if (!bad) begin
            for (int off = 0; off < nbytes; off += csz) begin
                len = (nbytes - off < csz) ? nbytes - off : csz;
                exp_we.push_back(1'b0); exp_addr.push_back(src + off); exp_len.push_back(len);
                exp_we.push_back(1'b1); exp_addr.push_back(dst + off); exp_len.push_back(len);
            end
        end
        total = exp_we.size();
        exp_err = bad || (e_at >= 0 && e_at < total);
        if (e_at >= 0) begin
            while (exp_we.size() > e_at + 1) begin
                void'(exp_we.pop_back()); void'(exp_addr.pop_back()); void'(exp_len.pop_back());
            end
        end
        err_at = e_at;
        acc_idx = 0;
        dc0 = done_cnt;
        ec0 = err_cnt;
        @(negedge clk);
        nxt_cfg_i = cfg; nxt_bytes_i = nbytes; nxt_src_i = src; nxt_dst_i = dst;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(clr_flags_o && busy_o, {"R2 clear pulse after start ", name}, clr_flags_o, 1);
        chk(exec_bytes_o == nbytes && exec_src_o == src && exec_dst_o == dst && exec_cfg_o == cfg,
            {"R2 descriptor latched ", name}, exec_src_o, src);
        if (poke) begin
            @(negedge clk);
            @(negedge clk);
            start_i = 1'b1; nxt_bytes_i = 99; nxt_src_i = 0; nxt_dst_i = 'h3F0;
            @(negedge clk);
            start_i = 1'b0;
        end
        cyc = 0;
        while (busy_o && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(!busy_o && !mem_req_o, {"R12 back to idle ", name}, busy_o, 0);
        chk(exp_we.size() == 0, {"R4 all expected requests issued ", name}, exp_we.size(), 0);
        if (exp_err) begin
            chk(err_cnt == ec0 + 1 && done_cnt == dc0,
                bad ? {"R7 early error ", name} : {"R8 error on bus fault ", name}, err_cnt - ec0, 1);
            if (bad) chk(exec_bytes_o == nbytes && acc_idx == 0, {"R7 no access, no progress ", name},
                         acc_idx, 0);
        end else begin
            chk(done_cnt == dc0 + 1 && err_cnt == ec0, {"R9 single done pulse ", name}, done_cnt - dc0, 1);
            if (cfg[3]) begin
                chk(exec_bytes_o == nbytes && exec_src_o == src && exec_dst_o == dst,
                    {"R10 repeat restores descriptor ", name}, exec_bytes_o, nbytes);
            end else begin
                chk(exec_bytes_o == 0 && exec_src_o == src + nbytes && exec_dst_o == dst + nbytes,
                    {"R5 final working registers ", name}, exec_src_o, src + nbytes);
            end
            mism = 0;
            for (int i = 0; i < nbytes; i++)
                if (mem[(dst + i) & 1023] != 8'(((src + i) * 7 + 3) & 255)) mism++;
            chk(mism == 0, {"R6 destination equals source ", name}, mism, 0);
            if (poke) chk(exec_src_o == src + nbytes && exec_dst_o == dst + nbytes,
                          {"R11 start while busy ignored ", name}, exec_dst_o, dst + nbytes);
        end
    endtask

    bit finished = 1'b0;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 7 + 3) & 255);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !mem_req_o && !done_o && !err_o && exec_bytes_o == 0 && exec_src_o == 0,
            "R1 reset idle", busy_o, 0);
        run_case(4'h3, 20, 'h010, 'h200, -1, 1'b0, "8B chunks plus 4B tail");
        run_case(4'h2, 12, 'h020, 'h240, -1, 1'b0, "4B chunks exact");
        run_case(4'h6, 16, 'h040, 'h280, -1, 1'b0, "R3 size field capped");
        run_case(4'h0, 3,  'h051, 'h2C3, -1, 1'b0, "1B chunks");
        run_case(4'h3, 0,  'h010, 'h200, -1, 1'b0, "zero count");
        run_case(4'h3, 16, 'h044, 'h300, -1, 1'b0, "misaligned source");
        run_case(4'h1, 4,  'h010, 'h3C1, -1, 1'b0, "misaligned destination");
        run_case(4'h2, 12, 'h060, 'h300, 2,  1'b0, "read fault");
        run_case(4'h2, 12, 'h060, 'h320, 1,  1'b0, "write fault");
        run_case(4'hB, 13, 'h080, 'h340, -1, 1'b0, "repeat");
        run_case(4'h3, 24, 'h090, 'h380, -1, 1'b1, "start while busy");
        run_case(4'h2, 8,  'h0B0, 'h3C8, -1, 1'b0, "R12 restart after fault");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule